// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block is a small set of binary lock flags that two independent ports, called left and right, can claim and release. It sits beside a shared data memory but uses none of its storage. A port talks to the bank by pulling its active-low semaphore select. The low address bits choose one flag, and only bit 0 of the write data carries meaning. Writing 0 asks for the flag and writing 1 gives up the request. Software claims a lock with a write-then-read sequence: it writes 0, reads the flag back, and owns the lock if the read returns 0.

Each flag holds one request bit per side and an owner state (free, left or right). A request from the side that does not own the flag stays pending. When the owner releases, the flag passes straight to the pending side, so that side never has to retry its write. If both sides claim a free flag on the same clock edge, exactly one side wins; in this build the winner is set by a parameter and defaults to the left side. Each side has a read register that loads the flag value when that side's read window opens (select and output enable both low). The register then holds that value until the window closes, so a polling loop must drop one of the two enables between reads.

Top module: `hwsem_bank`

## Requirements
- R1: After reset no flag has an owner or a request, and every flag reads as 1 from both sides.
- R2: Address bits 2:0 select one of the eight flags (index = binary value). Higher address bits have no effect on which flag is accessed.
- R3: A write changes state only through write-data bit 0. Every other data bit is ignored.
- R4: A write of 0 to a free flag makes that side the owner. The owner then reads 0 and the other side reads 1.
- R5: While one side owns a flag, writes from the other side (0 or 1) do not change the owner. Only a write of 1 from the owner releases the flag.
- R6: A 0 written by the non-owner is kept as a pending request. On the edge where the owner writes 1, ownership moves to the pending side.
- R7: If the owner writes 1 and the other side has no pending request, the flag becomes free and reads 1 on both sides.
- R8: If both sides write 0 to the same free flag on one edge, exactly one side becomes owner. With the default tie setting the left side wins and reads 0, and the right side reads 1 with its request pending.
- R9: A read returns the flag value on all 16 data bits (0x0000 or 0xFFFF).
- R10: The read value is taken on the first edge where select and output enable are both low, and appears on the data output one cycle later. It stays fixed while both remain low, even if the flag changes.
- R11: A write made while the RAM chip select (active low) and the semaphore select are both low is ignored.
- R12: When a side's read window was not open on the previous edge, that side's data output is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_sem_n | input | 1 | Left semaphore select, active low |
| lt_cs_n | input | 1 | Left RAM chip select, active low (a write is blocked when this is low) |
| lt_we_n | input | 1 | Left write enable, active low |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_addr | input | 13 | Left address; bits 2:0 pick the flag |
| lt_wdata | input | 16 | Left write data; only bit 0 is used |
| lt_rdata | output | 16 | Left read data, the held flag value on all bits |
| rt_sem_n | input | 1 | Right semaphore select, active low |
| rt_cs_n | input | 1 | Right RAM chip select, active low (a write is blocked when this is low) |
| rt_we_n | input | 1 | Right write enable, active low |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_addr | input | 13 | Right address; bits 2:0 pick the flag |
| rt_wdata | input | 16 | Right write data; only bit 0 is used |
| rt_rdata | output | 16 | Right read data, the held flag value on all bits |

## Verification
The bench tests hand-over by leaving a right-side request pending and then releasing from the left. A design that dropped pending requests would leave the flag free, and the right side would read 1 instead of 0. A same-edge claim from both sides checks that one side, and only one, sees 0. A broken tie rule would show both sides owning the flag, or neither. The read-hold test has the right side take the flag while its own read window stays open: a design without the hold register would show 0x0000 early, where 0xFFFF is expected until the window is reopened. Writes with high address bits set, writes with junk in the upper data bits, and writes blocked by the RAM chip select would each land on the wrong flag or change state if decoding were wrong.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } sem_owner_t;

endpackage

// File: rtl/hwsem_port_dec.sv
module hwsem_port_dec #(
   parameter int ADDR_W  = 13,
   parameter int DATA_W  = 16,
   parameter int NUM_SEM = 8
) (
   input  logic                       sem_n,
   input  logic                       cs_n,
   input  logic                       we_n,
   input  logic                       oe_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_SEM-1:0]         wr_hit,
   output logic                       wr_bit,
   output logic                       wr_any,
   output logic                       rd_win,
   output logic [$clog2(NUM_SEM)-1:0] rd_idx
);

   localparam int IDX_W = $clog2(NUM_SEM);

   logic [IDX_W-1:0] idx;
   logic             unused_bits;

   assign idx         = addr[IDX_W-1:0];
   assign wr_any      = !sem_n && !we_n && cs_n;
   assign wr_bit      = wdata[0];
   assign rd_win      = !sem_n && !oe_n;
   assign rd_idx      = idx;
   assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

   for (genvar g = 0; g < NUM_SEM; g++) begin : g_hit
      assign wr_hit[g] = wr_any && (idx == IDX_W'(g));
   end

endmodule

// File: rtl/hwsem_cell.sv
module hwsem_cell
   import hwsem_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_l,
   input  logic wb_l,
   input  logic wr_r,
   input  logic wb_r,
   output logic flag_l,
   output logic flag_r
);

   sem_owner_t st_q, st_d;
   logic       req_l_q, req_r_q;
   logic       req_l_d, req_r_d;

   assign req_l_d = wr_l ? !wb_l : req_l_q;
   assign req_r_d = wr_r ? !wb_r : req_r_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         OWN_NONE: begin
            if (req_l_d && req_r_d) st_d = TIE_LEFT ? OWN_LEFT : OWN_RIGHT;
            else if (req_l_d)       st_d = OWN_LEFT;
            else if (req_r_d)       st_d = OWN_RIGHT;
         end
         OWN_LEFT: begin
            if (!req_l_d) st_d = req_r_d ? OWN_RIGHT : OWN_NONE;
         end
         OWN_RIGHT: begin
            if (!req_r_d) st_d = req_l_d ? OWN_LEFT : OWN_NONE;
         end
         default: st_d = OWN_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= OWN_NONE;
         req_l_q <= 1'b0;
         req_r_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         req_l_q <= req_l_d;
         req_r_q <= req_r_d;
      end
   end

   assign flag_l = (st_q != OWN_LEFT);
   assign flag_r = (st_q != OWN_RIGHT);

   p_grab_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OWN_NONE && wr_l && !wb_l && !wr_r) |=> (st_q == OWN_LEFT));

   p_keep_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OWN_LEFT && !(wr_l && wb_l)) |=> (st_q == OWN_LEFT));

   p_keep_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OWN_RIGHT && !(wr_r && wb_r)) |=> (st_q == OWN_RIGHT));

   p_handover_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OWN_LEFT && wr_l && wb_l && req_r_q && !wr_r) |=> (st_q == OWN_RIGHT));

   p_release_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OWN_RIGHT && wr_r && wb_r && !req_l_q && !wr_l) |=> (flag_l && flag_r));

   p_tie_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OWN_NONE && wr_l && !wb_l && wr_r && !wb_r) |=> (flag_l != flag_r));

endmodule

// File: rtl/hwsem_rd_hold.sv
module hwsem_rd_hold #(
   parameter int DATA_W  = 16,
   parameter int NUM_SEM = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_win,
   input  logic [$clog2(NUM_SEM)-1:0] rd_idx,
   input  logic [NUM_SEM-1:0]         flags,
   output logic [DATA_W-1:0]          rdata
);

   logic win_q;
   logic hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         win_q <= rd_win;
         if (rd_win && !win_q) hold_q <= flags[rd_idx];
      end
   end

   assign rdata = win_q ? {DATA_W{hold_q}} : '0;

   p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_win && win_q) |=> $stable(rdata));

   p_full_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      win_q |-> ($countones(rdata) == 0 || $countones(rdata) == DATA_W));

endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank #(
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 16,
   parameter int NUM_SEM  = 8,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lt_sem_n,
   input  logic              lt_cs_n,
   input  logic              lt_we_n,
   input  logic              lt_oe_n,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic [DATA_W-1:0] lt_wdata,
   output logic [DATA_W-1:0] lt_rdata,
   input  logic              rt_sem_n,
   input  logic              rt_cs_n,
   input  logic              rt_we_n,
   input  logic              rt_oe_n,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic [DATA_W-1:0] rt_wdata,
   output logic [DATA_W-1:0] rt_rdata
);

   localparam int IDX_W = $clog2(NUM_SEM);

   if (NUM_SEM < 2 || (1 << IDX_W) != NUM_SEM) begin : g_bad_num
      $error("hwsem_bank: NUM_SEM must be a power of two, at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("hwsem_bank: ADDR_W too narrow for NUM_SEM");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("hwsem_bank: DATA_W must be positive");
   end

   logic [NUM_SEM-1:0] hit_l, hit_r;
   logic               bit_l, bit_r;
   logic               any_l, any_r;
   logic               win_l, win_r;
   logic [IDX_W-1:0]   idx_l, idx_r;
   logic [NUM_SEM-1:0] flags_l, flags_r;

   hwsem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_l (
      .sem_n (lt_sem_n), .cs_n (lt_cs_n), .we_n (lt_we_n), .oe_n (lt_oe_n),
      .addr  (lt_addr),  .wdata(lt_wdata),
      .wr_hit(hit_l), .wr_bit(bit_l), .wr_any(any_l), .rd_win(win_l), .rd_idx(idx_l)
   );

   hwsem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_r (
      .sem_n (rt_sem_n), .cs_n (rt_cs_n), .we_n (rt_we_n), .oe_n (rt_oe_n),
      .addr  (rt_addr),  .wdata(rt_wdata),
      .wr_hit(hit_r), .wr_bit(bit_r), .wr_any(any_r), .rd_win(win_r), .rd_idx(idx_r)
   );

   for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
      hwsem_cell #(.TIE_LEFT(TIE_LEFT)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_l  (hit_l[g]),
         .wb_l  (bit_l),
         .wr_r  (hit_r[g]),
         .wb_r  (bit_r),
         .flag_l(flags_l[g]),
         .flag_r(flags_r[g])
      );
   end

   hwsem_rd_hold #(.DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_hold_l (
      .clk(clk), .rst_n(rst_n), .rd_win(win_l), .rd_idx(idx_l),
      .flags(flags_l), .rdata(lt_rdata)
   );

   hwsem_rd_hold #(.DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_hold_r (
      .clk(clk), .rst_n(rst_n), .rd_win(win_r), .rd_idx(idx_r),
      .flags(flags_r), .rdata(rt_rdata)
   );

   p_cs_block_l_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!lt_sem_n && !lt_cs_n) |-> (hit_l == '0));

   p_cs_block_r_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!rt_sem_n && !rt_cs_n) |-> (hit_r == '0));

   p_never_both_own_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_l | flags_r) == {NUM_SEM{1'b1}});

   p_write_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_l |-> $onehot(hit_l));

   p_write_onehot_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_r |-> $onehot(hit_r));

endmodule

// File: tb/hwsem_bank_test.sv
module hwsem_bank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lt_sem_n = 1'b1, lt_cs_n = 1'b1, lt_we_n = 1'b1, lt_oe_n = 1'b1;
   logic [12:0] lt_addr = '0;
   logic [15:0] lt_wdata = '0;
   logic [15:0] lt_rdata;
   logic        rt_sem_n = 1'b1, rt_cs_n = 1'b1, rt_we_n = 1'b1, rt_oe_n = 1'b1;
   logic [12:0] rt_addr = '0;
   logic [15:0] rt_wdata = '0;
   logic [15:0] rt_rdata;

   int    n_total = 0;
   int    n_fail  = 0;
   string cur_tag = "R1";
   bit    done    = 1'b0;

   always #10 clk = ~clk;

   hwsem_bank uut (
      .clk(clk), .rst_n(rst_n),
      .lt_sem_n(lt_sem_n), .lt_cs_n(lt_cs_n), .lt_we_n(lt_we_n), .lt_oe_n(lt_oe_n),
      .lt_addr(lt_addr), .lt_wdata(lt_wdata), .lt_rdata(lt_rdata),
      .rt_sem_n(rt_sem_n), .rt_cs_n(rt_cs_n), .rt_we_n(rt_we_n), .rt_oe_n(rt_oe_n),
      .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata)
   );

   // behavioural reference: owner 0 free, 1 left, 2 right
   int owner [8];
   bit pend_l [8];
   bit pend_r [8];
   bit mh_l, mh_r, mw_l, mw_r;

   always @(posedge clk) begin
      bit wl, wr, open_l, open_r, nl, nr;
      int il, ir;
      if (!rst_n) begin
         for (int s = 0; s < 8; s++) begin
            owner[s] = 0; pend_l[s] = 0; pend_r[s] = 0;
         end
         mh_l = 0; mh_r = 0; mw_l = 0; mw_r = 0;
      end else begin
         il = int'(lt_addr[2:0]);
         ir = int'(rt_addr[2:0]);
         wl = !lt_sem_n && !lt_we_n && lt_cs_n;
         wr = !rt_sem_n && !rt_we_n && rt_cs_n;
         open_l = !lt_sem_n && !lt_oe_n;
         open_r = !rt_sem_n && !rt_oe_n;
         if (open_l && !mw_l) mh_l = (owner[il] != 1);
         if (open_r && !mw_r) mh_r = (owner[ir] != 2);
         mw_l = open_l;
         mw_r = open_r;
         for (int s = 0; s < 8; s++) begin
            nl = pend_l[s];
            nr = pend_r[s];
            if (wl && il == s) nl = !lt_wdata[0];
            if (wr && ir == s) nr = !rt_wdata[0];
            pend_l[s] = nl;
            pend_r[s] = nr;
            if (owner[s] == 0) owner[s] = nl ? 1 : (nr ? 2 : 0);
            else if (owner[s] == 1 && !nl) owner[s] = nr ? 2 : 0;
            else if (owner[s] == 2 && !nr) owner[s] = nl ? 1 : 0;
         end
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({cur_tag, " model left"},  lt_rdata, mw_l ? {16{mh_l}} : 16'h0000);
         check({cur_tag, " model right"}, rt_rdata, mw_r ? {16{mh_r}} : 16'h0000);
      end
   end

   task automatic rd(input bit right, input logic [12:0] a, input bit exp, input string tag);
      @(negedge clk);
      if (right) begin rt_sem_n = 0; rt_oe_n = 0; rt_addr = a; end
      else       begin lt_sem_n = 0; lt_oe_n = 0; lt_addr = a; end
      @(negedge clk);
      check(tag, right ? rt_rdata : lt_rdata, {16{exp}});
      if (right) begin rt_sem_n = 1; rt_oe_n = 1; end
      else       begin lt_sem_n = 1; lt_oe_n = 1; end
      @(negedge clk);
      check({tag, " R12 idle"}, right ? rt_rdata : lt_rdata, 16'h0000);
   endtask

   task automatic wr(input bit right, input logic [12:0] a, input logic [15:0] d, input bit cs_low);
      @(negedge clk);
      if (right) begin rt_sem_n = 0; rt_we_n = 0; rt_addr = a; rt_wdata = d; rt_cs_n = !cs_low; end
      else       begin lt_sem_n = 0; lt_we_n = 0; lt_addr = a; lt_wdata = d; lt_cs_n = !cs_low; end
      @(negedge clk);
      if (right) begin rt_sem_n = 1; rt_we_n = 1; rt_cs_n = 1; end
      else       begin lt_sem_n = 1; lt_we_n = 1; lt_cs_n = 1; end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_total++; n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1 / R12: reset state
      cur_tag = "R1";
      @(negedge clk);
      check("R12 reset left idle", lt_rdata, 16'h0000);
      check("R12 reset right idle", rt_rdata, 16'h0000);
      for (int s = 0; s < 8; s++) rd(0, 13'(s), 1'b1, "R1 left free");
      rd(1, 13'd7, 1'b1, "R1 right free");

      // R2, R3, R4: left claims flag 3 via high address bits and junk data
      cur_tag = "R4";
      wr(0, 13'h1FFB, 16'hFFFE, 0);
      rd(0, 13'd3, 1'b0, "R4 left owner");
      rd(1, 13'd3, 1'b1, "R4 right sees taken");
      rd(0, 13'd2, 1'b1, "R2 neighbour untouched");
      rd(0, 13'h0A03, 1'b0, "R2 high bits alias");

      // R5: right tries to take and release; left keeps it
      cur_tag = "R5";
      wr(1, 13'd3, 16'h0001, 0);
      rd(0, 13'd3, 1'b0, "R5 right release no effect");
      wr(1, 13'd3, 16'h0000, 0);
      rd(1, 13'd3, 1'b1, "R5 right request blocked");
      rd(0, 13'd3, 1'b0, "R5 left still owner");

      // R6: left release hands over to pending right; R3 data bit 0 only
      cur_tag = "R6";
      wr(0, 13'd3, 16'h0001, 0);
      rd(1, 13'd3, 1'b0, "R6 right got handover");
      rd(0, 13'd3, 1'b1, "R6 left lost flag");

      // R7: right releases with nothing pending
      cur_tag = "R7";
      wr(1, 13'h1003, 16'hFFFF, 0);
      rd(0, 13'd3, 1'b1, "R7 free left");
      rd(1, 13'd3, 1'b1, "R7 free right");

      // R3: junk upper bits with bit 0 = 1 must not request
      cur_tag = "R3";
      wr(0, 13'd4, 16'hFFFF, 0);
      rd(0, 13'd4, 1'b1, "R3 bit0 one no request");
      rd(1, 13'd4, 1'b1, "R3 right view");

      // R8: simultaneous claim on flag 5
      cur_tag = "R8";
      @(negedge clk);
      lt_sem_n = 0; lt_we_n = 0; lt_addr = 13'd5; lt_wdata = 16'h0000;
      rt_sem_n = 0; rt_we_n = 0; rt_addr = 13'd5; rt_wdata = 16'h0000;
      @(negedge clk);
      lt_sem_n = 1; lt_we_n = 1; rt_sem_n = 1; rt_we_n = 1;
      rd(0, 13'd5, 1'b0, "R8 left wins tie");
      rd(1, 13'd5, 1'b1, "R8 right loses tie");
      wr(0, 13'd5, 16'h0001, 0);
      rd(1, 13'd5, 1'b0, "R8 R6 loser pending then owner");
      wr(1, 13'd5, 16'h0001, 0);
      rd(0, 13'd5, 1'b1, "R8 freed");

      // R11: write with RAM chip select low is ignored
      cur_tag = "R11";
      wr(1, 13'd1, 16'h0000, 1);
      rd(1, 13'd1, 1'b1, "R11 right blocked write");
      rd(0, 13'd1, 1'b1, "R11 left view");

      // R10 / R9: held read while the right side takes flag 6
      cur_tag = "R10";
      @(negedge clk);
      rt_sem_n = 0; rt_oe_n = 0; rt_addr = 13'd6;
      @(negedge clk);
      check("R10 R9 opened read", rt_rdata, 16'hFFFF);
      rt_we_n = 0; rt_wdata = 16'h0000;
      @(negedge clk);
      rt_we_n = 1;
      check("R10 held after own claim", rt_rdata, 16'hFFFF);
      @(negedge clk);
      check("R10 still held", rt_rdata, 16'hFFFF);
      rt_sem_n = 1; rt_oe_n = 1;
      rd(1, 13'd6, 1'b0, "R10 R9 reopened read");
      rd(0, 13'd6, 1'b1, "R10 left view");
      wr(1, 13'd6, 16'h0001, 0);
      rd(0, 13'd6, 1'b1, "R7 flag 6 free");

      repeat (2) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule